// File: doc/BRIEF.md
# Serial Frame Position Strobe Generator

This block follows the bit position inside a serial DS3 or E3 frame and produces the timing strobes that an external bit-serial data port needs. On the transmit side it gives upstream logic early notice. A start-of-frame pulse and a payload data-enable are both issued three bit clocks ahead of the bits they describe, which leaves the source time to supply each bit on time. On the receive side the strobes line up with the bit now on the serial output: a start-of-frame marker, a payload data-enable, and a clock-enable that gates the bit clock so the gated clock has no edges during overhead bits.

Each side has one shared strobe pin. A select input chooses whether that pin carries the start-of-frame function or the data-enable function. Each pin has its own polarity inversion. A launch-edge control moves every output from the rising edge of the bit clock to the following falling edge, for use when the reference clock is inverted. The frame layout has two forms:

- DS3: a 4760-bit frame in which every 85th bit is overhead.
- E3: a 1536-bit frame whose first 12 bits are overhead.

Line coding, frame alignment search and overhead content are handled elsewhere.

Top module: `frame_strobe_gen`

## Requirements
- R1: While `rst_n` is low (synchronous), the receive side reports frame bit 0 and the transmit side reports frame bit 3. After n rising edges with `rst_n` high, the receive side reports bit n mod L and the transmit side reports bit (n+3) mod L, where L is the frame length.
- R2: With `mode_e3`=0 the frame is 4760 bits long. A bit p is overhead when p mod 85 = 0 and is payload otherwise.
- R3: With `mode_e3`=1 the frame is 1536 bits long. Bits 0 to 11 are overhead and bits 12 to 1535 are payload.
- R4: The transmit start-of-frame strobe is high for exactly one clock, three clocks before frame bit 0 is due, that is while the current bit is L-3.
- R5: The transmit data-enable is high in a clock exactly when the bit due three clocks later is a payload bit. It therefore rises three clocks before a payload run starts and falls three clocks before that run ends.
- R6: The receive start-of-frame strobe is high in the clock in which frame bit 0 is on the receive serial output, and low in every other clock.
- R7: The receive data-enable is high in exactly those clocks in which the receive serial output carries a payload bit.
- R8: `rx_gclk_en` equals the uninverted receive data-enable. It is not affected by `rx_pin_sel` or `rx_inv`.
- R9: `tx_inv`=1 inverts `tx_strobe` and `rx_inv`=1 inverts `rx_strobe`. Each control acts only on its own pin.
- R10: With `fall_launch`=0 the outputs change just after the rising edge. With `fall_launch`=1 every output changes on the falling edge that follows, so for the first half of each clock it still shows the previous bit's value.
- R11: A pin select of 0 puts the start-of-frame function on that side's pin, and a select of 1 puts the data-enable function there.
- R12: The position counter wraps from L-1 to 0 with no gap. The transmit lead is taken modulo L, so strobes near the wrap point are correct in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_e3 | input | 1 | 0 = DS3 frame layout, 1 = E3 frame layout; change only under reset |
| tx_pin_sel | input | 1 | Transmit pin function: 0 = start of frame, 1 = data-enable |
| rx_pin_sel | input | 1 | Receive pin function: 0 = start of frame, 1 = data-enable |
| tx_inv | input | 1 | Invert the transmit strobe pin |
| rx_inv | input | 1 | Invert the receive strobe pin |
| fall_launch | input | 1 | Launch all outputs on the falling edge |
| tx_strobe | output | 1 | Transmit strobe pin, three clocks ahead |
| rx_strobe | output | 1 | Receive strobe pin, aligned with the current bit |
| rx_gclk_en | output | 1 | Glitch-free enable for the gapped receive clock |

## Verification
The assertions check on every clock that the transmit and receive position trackers keep exactly three bits apart: a transmit start-of-frame or data-enable level is always followed three clocks later by the same receive level. They also check that the transmit start-of-frame lasts a single clock, and that each mode's overhead positions never carry a data-enable. The absolute layout cannot be shown by those relations alone, because the assertions only compare the two trackers with each other. The bench's scenarios cover the rest: the 85-bit spacing, the 1536-bit frame with 12 overhead bits, the reset position, the behaviour across wrap, pin selection, polarity and the half-clock shift of falling-edge launch, each checked against a position model that the bench counts itself.

// File: rtl/fsg_pkg.sv
// Shared types for the frame strobe generator.
// Assumes: a strobe pair is always decoded for a single frame position.
package fsg_pkg;

    // Strobes decoded for one frame position
    typedef struct packed {
        logic sof;   // frame bit 0
        logic den;   // payload bit
    } strobe_t;

endpackage

// File: rtl/fsg_phase_track.sv
// Frame position tracker with a fixed lead.
// It tracks (bit position + LEAD) mod frame length and registers the
// start-of-frame and payload strobes that belong to that position.
// Assumes: mode_e3 changes only while rst_n is low, LEAD < E3_FRAME,
// and DS3_FRAME is a multiple of DS3_BLK.
module fsg_phase_track #(
    parameter int LEAD      = 0,
    parameter int DS3_BLK   = 85,
    parameter int DS3_FRAME = 4760,
    parameter int E3_FRAME  = 1536,
    parameter int E3_OH     = 12,
    localparam int IDX_W    = $clog2(DS3_FRAME > E3_FRAME ? DS3_FRAME : E3_FRAME),
    localparam int BLK_W    = $clog2(DS3_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_e3,
    output fsg_pkg::strobe_t strb
);
    localparam logic [IDX_W-1:0] IDX_RST  = IDX_W'(LEAD);
    localparam logic [BLK_W-1:0] BLK_RST  = BLK_W'(LEAD % DS3_BLK);
    localparam logic [IDX_W-1:0] DS3_LAST = IDX_W'(DS3_FRAME - 1);
    localparam logic [IDX_W-1:0] E3_LAST  = IDX_W'(E3_FRAME - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(DS3_BLK - 1);
    localparam logic [IDX_W-1:0] OH_END   = IDX_W'(E3_OH);

    logic [IDX_W-1:0] idx, idx_nx;
    logic [BLK_W-1:0] blk, blk_nx;
    logic             at_end;
    fsg_pkg::strobe_t strb_nx;

    // Next position: reset value, or increment with wrap at frame and block end
    always_comb begin
        at_end = (idx == (mode_e3 ? E3_LAST : DS3_LAST));
        if (!rst_n) begin
            idx_nx = IDX_RST;
            blk_nx = BLK_RST;
        end else begin
            idx_nx = at_end ? '0 : idx + 1'b1;
            blk_nx = (at_end || blk == BLK_LAST) ? '0 : blk + 1'b1;
        end
    end

    // Decode the strobes for the next position so they are registered in step with it
    always_comb begin
        strb_nx.sof = (idx_nx == '0);
        strb_nx.den = mode_e3 ? (idx_nx >= OH_END) : (blk_nx != '0);
    end

    // Position and strobe registers
    always_ff @(posedge clk) begin
        idx  <= idx_nx;
        blk  <= blk_nx;
        strb <= strb_nx;
    end

endmodule

// File: rtl/fsg_launch.sv
// Output launch stage: it selects the rising-edge or falling-edge copy of
// each strobe and applies that strobe's polarity inversion.
// Assumes: d comes from rising-edge registers, and inv and fall are static.
// The falling-edge copy only follows d and needs no reset of its own,
// because d is reset.
module fsg_launch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic [N-1:0] d,
    input  logic [N-1:0] inv,
    input  logic         fall,
    output logic [N-1:0] q
);
    logic [N-1:0] neg_q;

    // Half-cycle delayed copy for falling-edge launch
    always_ff @(negedge clk) begin
        neg_q <= d;
    end

    // Per-output launch edge selection and polarity
    for (genvar i = 0; i < N; i++) begin : g_out
        assign q[i] = (fall ? neg_q[i] : d[i]) ^ inv[i];
    end

endmodule

// File: rtl/frame_strobe_gen.sv
// Top level of the frame strobe generator. It holds two position trackers:
// lane 0 has no lead and serves the receive side, lane 1 leads by TX_LEAD
// and serves the transmit side. Each side's strobe pin carries the function
// chosen by its select, and all outputs pass through the launch stage.
// Assumes: configuration inputs change only while rst_n is low.
module frame_strobe_gen #(
    parameter int DS3_BLK   = 85,
    parameter int DS3_FRAME = 4760,
    parameter int E3_FRAME  = 1536,
    parameter int E3_OH     = 12,
    parameter int TX_LEAD   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_e3,
    input  logic tx_pin_sel,
    input  logic rx_pin_sel,
    input  logic tx_inv,
    input  logic rx_inv,
    input  logic fall_launch,
    output logic tx_strobe,
    output logic rx_strobe,
    output logic rx_gclk_en
);
    localparam int LANES = 2;
    localparam int RX = 0;
    localparam int TX = 1;

    fsg_pkg::strobe_t strb [LANES];
    logic [LANES-1:0] sof_v, den_v;
    logic [2:0]       raw, pol, launched;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fsg_phase_track #(
            .LEAD      (l == TX ? TX_LEAD : 0),
            .DS3_BLK   (DS3_BLK),
            .DS3_FRAME (DS3_FRAME),
            .E3_FRAME  (E3_FRAME),
            .E3_OH     (E3_OH)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_e3 (mode_e3),
            .strb    (strb[l])
        );
        assign sof_v[l] = strb[l].sof;
        assign den_v[l] = strb[l].den;
    end

    // Pin function selection; the gated clock enable always follows the receive data-enable
    always_comb begin
        raw[0] = tx_pin_sel ? den_v[TX] : sof_v[TX];
        raw[1] = rx_pin_sel ? den_v[RX] : sof_v[RX];
        raw[2] = den_v[RX];
        pol    = {1'b0, rx_inv, tx_inv};
    end

    fsg_launch #(.N(3)) u_launch (
        .clk  (clk),
        .d    (raw),
        .inv  (pol),
        .fall (fall_launch),
        .q    (launched)
    );

    assign tx_strobe  = launched[0];
    assign rx_strobe  = launched[1];
    assign rx_gclk_en = launched[2];

endmodule

// File: rtl/fsg_checker.sv
// Assertion checker for frame_strobe_gen, attached with bind.
// It relates the transmit tracker (lane 1) to the receive tracker (lane 0)
// and checks the overhead positions of each mode.
module fsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_e3,
    input logic [1:0] sof_v,
    input logic [1:0] den_v
);
    // R4
    tx_sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_v[1] |=> !sof_v[1]);

    // R6
    sof_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_v[1] |-> ##3 sof_v[0]);

    // R5
    den_rise_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        den_v[1] |-> ##3 den_v[0]);

    // R7
    den_fall_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !den_v[1] |-> ##3 !den_v[0]);

    // R2
    ds3_oh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_e3 && sof_v[0]) |-> !den_v[0]);

    // R3
    e3_oh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e3 && sof_v[0]) |=> !den_v[0]);

endmodule

bind frame_strobe_gen fsg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_e3 (mode_e3),
    .sof_v   (sof_v),
    .den_v   (den_v)
);

// File: tb/tb_frame_strobe_gen.sv
// Directed bench for frame_strobe_gen. It keeps its own count of clocks
// since reset and predicts every output from the frame layout.
module tb_frame_strobe_gen;
    logic clk = 0;
    logic rst_n = 0;
    logic mode_e3 = 0, tx_pin_sel = 0, rx_pin_sel = 0;
    logic tx_inv = 0, rx_inv = 0, fall_launch = 0;
    logic tx_strobe, rx_strobe, rx_gclk_en;
    int n = 0;
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frame_strobe_gen dut (.*);

    function automatic int flen();
        return mode_e3 ? 1536 : 4760;
    endfunction

    function automatic logic m_sof(int i);
        return (i % flen()) == 0;
    endfunction

    function automatic logic m_den(int i);
        if (mode_e3) return (i % 1536) >= 12;
        return ((i % 4760) % 85) != 0;
    endfunction

    function automatic logic exp_tx(int i);
        return (tx_pin_sel ? m_den(i + 3) : m_sof(i + 3)) ^ tx_inv;
    endfunction

    function automatic logic exp_rx(int i);
        return (rx_pin_sel ? m_den(i) : m_sof(i)) ^ rx_inv;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at clock %0d: actual %b expected %b", req, what, n, act, exp);
        end
    endtask

    // Apply reset with the current configuration; n restarts at 0
    task automatic do_reset();
        @(posedge clk); #5 rst_n = 0;
        repeat (2) @(posedge clk);
        #5 rst_n = 1;
        n = 0;
    endtask

    // Step and compare all outputs each clock, late in the cycle
    task automatic scan(int cycles, string req);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); n++;
            #5;
            if (fall_launch && n > 1) begin
                chk({req, " R10"}, "tx early", tx_strobe, exp_tx(n - 1));
                chk({req, " R10"}, "rx early", rx_strobe, exp_rx(n - 1));
                chk({req, " R10"}, "gclk early", rx_gclk_en, m_den(n - 1));
            end
            #10;
            chk(req, "tx_strobe", tx_strobe, exp_tx(n));
            chk(req, "rx_strobe", rx_strobe, exp_rx(n));
            chk({req, " R8"}, "rx_gclk_en", rx_gclk_en, m_den(n));
        end
    endtask

    task automatic t_reset_state();
        mode_e3 = 0; tx_pin_sel = 0; rx_pin_sel = 0; tx_inv = 0; rx_inv = 0; fall_launch = 0;
        @(posedge clk); #5 rst_n = 0;
        repeat (2) @(posedge clk);
        #15;
        chk("R1", "rx sof in reset", rx_strobe, 1'b1);
        chk("R1", "tx sof in reset", tx_strobe, 1'b0);
        chk("R1", "gclk in reset", rx_gclk_en, 1'b0);
        #5 rst_n = 1; n = 0;
    endtask

    task automatic t_ds3_sof();
        mode_e3 = 0; tx_pin_sel = 0; rx_pin_sel = 0; tx_inv = 0; rx_inv = 0; fall_launch = 0;
        do_reset();
        scan(4760 + 20, "R2 R4 R6 R12");
    endtask

    task automatic t_ds3_den();
        mode_e3 = 0; tx_pin_sel = 1; rx_pin_sel = 1;
        do_reset();
        scan(4760 + 20, "R2 R5 R7 R11 R12");
    endtask

    task automatic t_e3_both();
        mode_e3 = 1; tx_pin_sel = 0; rx_pin_sel = 1;
        do_reset();
        scan(1536 + 20, "R3 R4 R7 R11 R12");
        tx_pin_sel = 1; rx_pin_sel = 0;
        do_reset();
        scan(1536 + 20, "R3 R5 R6 R11 R12");
    endtask

    task automatic t_polarity();
        mode_e3 = 1; tx_pin_sel = 1; rx_pin_sel = 0; tx_inv = 1; rx_inv = 0;
        do_reset();
        scan(60, "R9 tx");
        tx_inv = 0; rx_inv = 1;
        do_reset();
        scan(60, "R9 rx");
        rx_inv = 0;
    endtask

    task automatic t_fall_launch();
        mode_e3 = 0; tx_pin_sel = 0; rx_pin_sel = 1; fall_launch = 1;
        do_reset();
        scan(200, "R10");
        fall_launch = 0;
    endtask

    task automatic t_mid_reset();
        mode_e3 = 0; tx_pin_sel = 1; rx_pin_sel = 0;
        do_reset();
        scan(1000, "R1 run");
        do_reset();
        scan(200, "R1 restart");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_ds3_sof();
        t_ds3_den();
        t_e3_both();
        t_polarity();
        t_fall_launch();
        t_mid_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule